// File: doc/BRIEF.md
# Battery Charge Control Sequencer

This block is the digital controller of a single-cell lithium battery charger. External analog comparators reduce every voltage, current and temperature condition to a flag. The controller combines those flags with an active-low charge enable, an active-low timer enable and a periodic time-base tick. From them it decides which charge path is on: the low-current conditioning path or the fast path. The fast path covers both constant current and constant voltage, because the analog loop moves between those two by itself. The block also drives two active-low status bits, a supply-present flag and a fault flag.

Every slow transition is qualified by a deglitch filter. A filter counts ticks while its flag stays true and clears as soon as the flag drops. Two safety timers count ticks in the conditioning and fast phases. The controller starts a new charge without help when the battery sags after a finished charge, and again when the adapter comes back.

The states are SLEEP, STANDBY, PRECOND, FAST, DONE, SUSPEND and FAULT. Their transitions are listed below, in priority order:

- Undervoltage goes to SLEEP.
- SLEEP goes to STANDBY when the adapter is present and the enable is inactive. When the adapter is present and the enable is active, it goes to the start phase: PRECOND below the precharge level, FAST above it.
- A qualified adapter loss goes to SLEEP.
- An inactive enable goes to STANDBY.
- STANDBY goes to the start phase.
- PRECOND goes to FAULT on timer expiry, to SUSPEND on qualified temperature, and to FAST when the battery rises above the precharge level.
- FAST goes to FAULT on timer expiry, to SUSPEND on qualified temperature, to PRECOND on a qualified low battery, and to DONE on qualified termination.
- DONE goes to the start phase on a qualified recharge.
- SUSPEND goes back to the phase it left once the temperature flag clears.
- FAULT holds.

Top module: `chg_seq_top`

## Requirements
- R1: After reset the block is in SLEEP: both paths off, both status bits high (released), supply_ok low, fault low.
- R2: With the adapter present and chg_en_n low, the block starts in the conditioning phase if bat_above_pre is low. That phase has pre_en high and stat_chg_n low. The two paths are never on together.
- R3: In the conditioning phase, a high bat_above_pre moves the block to the fast phase (fast_en high, stat_chg_n low) on the next clock.
- R4: The fast phase returns to conditioning only after bat_above_pre has stayed low for DEGLITCH_TICKS ticks. If the flag rises before then, the count restarts from zero.
- R5: In the fast phase, the block moves to DONE after cur_below_term has stayed high with bat_below_rch low for DEGLITCH_TICKS ticks. DONE turns both paths off and drives stat_done_n low with stat_chg_n high.
- R6: In DONE, a bat_below_rch that stays high for DEGLITCH_TICKS ticks starts a new charge with both safety timers cleared.
- R7: PRECOND_TICKS enabled ticks spent in the conditioning phase lead to FAULT. FAULT drives both status bits low and fault high, with both paths off.
- R8: FAST_TICKS enabled ticks in the fast phase lead to FAULT. FAULT then holds while chg_en_n stays low and the adapter stays present.
- R9: While tmr_en_n is high, the safety timers do not advance.
- R10: A high chg_en_n puts the block in STANDBY on the next clock, from any state other than SLEEP. STANDBY has both paths off, status released and supply_ok high, and fault is cleared. A low chg_en_n then starts a fresh charge.
- R11: When adp_above_bat stays low for DEGLITCH_TICKS ticks, the block enters SLEEP and supply_ok goes low. When the adapter returns, charging restarts from the start phase.
- R12: When ts_out_win stays high for DEGLITCH_TICKS ticks in a charging phase, the block goes to SUSPEND: paths off, status released, safety timers held. When the flag clears, the block resumes the same phase with the timer values it had kept.
- R13: A high uvlo or otemp turns both paths off in the same cycle. A high uvlo also forces SLEEP on the next clock. A high otemp keeps the state and holds the timers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | One-cycle time-base pulse |
| chg_en_n | input | 1 | Charge enable, active low |
| tmr_en_n | input | 1 | Safety timer enable, active low |
| bat_above_pre | input | 1 | Battery above precharge-to-fast level |
| bat_below_rch | input | 1 | Battery below recharge level |
| cur_below_term | input | 1 | Charge current below termination level |
| adp_above_bat | input | 1 | Adapter voltage above battery voltage |
| uvlo | input | 1 | Supply undervoltage |
| otemp | input | 1 | Die overtemperature |
| ts_out_win | input | 1 | Pack temperature outside allowed window |
| pre_en | output | 1 | Conditioning current path enable |
| fast_en | output | 1 | Fast charge path enable |
| stat_chg_n | output | 1 | Status: charging, active low |
| stat_done_n | output | 1 | Status: charge complete, active low |
| supply_ok | output | 1 | Adapter present (state is not SLEEP) |
| fault | output | 1 | Safety timer fault |

## Verification
Inputs go straight into the state register, so a start, a rise above the precharge level, the enable, undervoltage and the end of a suspend all show at the outputs one clock after the input changes. Undervoltage and overtemperature also gate the path enables combinationally, in the same cycle. A deglitch or timer result needs one more clock after the tick that completes its count, because the counter reaches its limit on that tick and the state register follows on the next edge. The bench drives inputs and ticks at falling edges and leaves one settling edge after the last tick. It then samples at a falling edge, after every due result has arrived. Boundary rows apply one tick fewer than the limit and check that nothing has changed yet.

// File: rtl/chg_seq_pkg.sv
package chg_seq_pkg;

    typedef enum logic [2:0] {
        ST_SLEEP,
        ST_STANDBY,
        ST_PRECOND,
        ST_FAST,
        ST_DONE,
        ST_SUSPEND,
        ST_FAULT
    } chg_state_t;

    // deglitch filter slots
    localparam int DG_LOW   = 0;  // battery below precharge level
    localparam int DG_TERM  = 1;  // termination current
    localparam int DG_RCH   = 2;  // recharge request
    localparam int DG_SLEEP = 3;  // adapter lost
    localparam int DG_TEMP  = 4;  // pack temperature out of window
    localparam int NUM_DG   = 5;

endpackage

// File: rtl/chg_deglitch.sv
module chg_deglitch #(
    parameter int TICKS = 375
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic flag,
    output logic qual
);
    localparam int CW = $clog2(TICKS + 1);
    localparam logic [CW-1:0] LIM = CW'(TICKS);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!flag) begin
            cnt_q <= '0;
        end else if (tick && (cnt_q != LIM)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign qual = flag && (cnt_q == LIM);
endmodule

// File: rtl/chg_safety_timer.sv
module chg_safety_timer #(
    parameter int LIMIT = 1800
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (run && (cnt_q != LIM)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = (cnt_q == LIM);
endmodule

// File: rtl/chg_phase_fsm.sv
module chg_phase_fsm
    import chg_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       chg_en_n,
    input  logic       uvlo,
    input  logic       otemp,
    input  logic       adp_ok,
    input  logic       above_pre,
    input  logic       ts_out,
    input  logic       low_q,
    input  logic       term_q,
    input  logic       rch_q,
    input  logic       sleep_q,
    input  logic       temp_q,
    input  logic       pre_exp,
    input  logic       fast_exp,
    output chg_state_t state_o,
    output logic       pre_en,
    output logic       fast_en,
    output logic       stat_chg_n,
    output logic       stat_done_n,
    output logic       supply_ok,
    output logic       fault
);
    chg_state_t state_q, state_d, start_st;
    logic       susp_fast_q;
    logic       paths_blocked;

    assign start_st = above_pre ? ST_FAST : ST_PRECOND;

    // state register and the phase to resume after suspend
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_SLEEP;
            susp_fast_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_d == ST_SUSPEND && state_q != ST_SUSPEND) begin
                susp_fast_q <= (state_q == ST_FAST);
            end
        end
    end

    // next state, highest priority first
    always_comb begin
        state_d = state_q;
        if (uvlo) begin
            state_d = ST_SLEEP;
        end else if (state_q == ST_SLEEP) begin
            if (adp_ok) begin
                state_d = chg_en_n ? ST_STANDBY : start_st;
            end
        end else if (sleep_q) begin
            state_d = ST_SLEEP;
        end else if (chg_en_n) begin
            state_d = ST_STANDBY;
        end else begin
            unique case (state_q)
                ST_SLEEP:   state_d = state_q;
                ST_STANDBY: state_d = start_st;
                ST_PRECOND: begin
                    if (pre_exp)        state_d = ST_FAULT;
                    else if (temp_q)    state_d = ST_SUSPEND;
                    else if (above_pre) state_d = ST_FAST;
                end
                ST_FAST: begin
                    if (fast_exp)       state_d = ST_FAULT;
                    else if (temp_q)    state_d = ST_SUSPEND;
                    else if (low_q)     state_d = ST_PRECOND;
                    else if (term_q)    state_d = ST_DONE;
                end
                ST_DONE: begin
                    if (rch_q)          state_d = start_st;
                end
                ST_SUSPEND: begin
                    if (!ts_out)        state_d = susp_fast_q ? ST_FAST : ST_PRECOND;
                end
                ST_FAULT:   state_d = ST_FAULT;
                default:    state_d = ST_SLEEP;
            endcase
        end
    end

    // outputs
    assign paths_blocked = uvlo | otemp;

    always_comb begin
        pre_en      = (state_q == ST_PRECOND) && !paths_blocked;
        fast_en     = (state_q == ST_FAST) && !paths_blocked;
        stat_chg_n  = !((state_q == ST_PRECOND) || (state_q == ST_FAST) || (state_q == ST_FAULT));
        stat_done_n = !((state_q == ST_DONE) || (state_q == ST_FAULT));
        supply_ok   = (state_q != ST_SLEEP);
        fault       = (state_q == ST_FAULT);
    end

    assign state_o = state_q;
endmodule

// File: rtl/chg_seq_top.sv
module chg_seq_top
    import chg_seq_pkg::*;
#(
    parameter int DEGLITCH_TICKS = 375,
    parameter int PRECOND_TICKS  = 1800000,
    parameter int FAST_TICKS     = 25200000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic chg_en_n,
    input  logic tmr_en_n,
    input  logic bat_above_pre,
    input  logic bat_below_rch,
    input  logic cur_below_term,
    input  logic adp_above_bat,
    input  logic uvlo,
    input  logic otemp,
    input  logic ts_out_win,
    output logic pre_en,
    output logic fast_en,
    output logic stat_chg_n,
    output logic stat_done_n,
    output logic supply_ok,
    output logic fault
);
    logic [NUM_DG-1:0] dg_flag;
    logic [NUM_DG-1:0] dg_qual;
    chg_state_t        state;
    logic              timers_clr, tmr_tick, pre_exp, fast_exp;

    assign dg_flag[DG_LOW]   = !bat_above_pre;
    assign dg_flag[DG_TERM]  = cur_below_term && !bat_below_rch;
    assign dg_flag[DG_RCH]   = bat_below_rch;
    assign dg_flag[DG_SLEEP] = !adp_above_bat;
    assign dg_flag[DG_TEMP]  = ts_out_win;

    for (genvar g = 0; g < NUM_DG; g++) begin : g_dg
        chg_deglitch #(.TICKS(DEGLITCH_TICKS)) u_dg (
            .clk  (clk),
            .rst_n(rst_n),
            .tick (tick),
            .flag (dg_flag[g]),
            .qual (dg_qual[g])
        );
    end

    assign timers_clr = (state == ST_SLEEP) || (state == ST_STANDBY) || (state == ST_DONE);
    assign tmr_tick   = tick && !tmr_en_n && !otemp && !uvlo;

    chg_safety_timer #(.LIMIT(PRECOND_TICKS)) u_pre_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (timers_clr),
        .run    (tmr_tick && (state == ST_PRECOND)),
        .expired(pre_exp)
    );

    chg_safety_timer #(.LIMIT(FAST_TICKS)) u_fast_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (timers_clr),
        .run    (tmr_tick && (state == ST_FAST)),
        .expired(fast_exp)
    );

    chg_phase_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .chg_en_n   (chg_en_n),
        .uvlo       (uvlo),
        .otemp      (otemp),
        .adp_ok     (adp_above_bat),
        .above_pre  (bat_above_pre),
        .ts_out     (ts_out_win),
        .low_q      (dg_qual[DG_LOW]),
        .term_q     (dg_qual[DG_TERM]),
        .rch_q      (dg_qual[DG_RCH]),
        .sleep_q    (dg_qual[DG_SLEEP]),
        .temp_q     (dg_qual[DG_TEMP]),
        .pre_exp    (pre_exp),
        .fast_exp   (fast_exp),
        .state_o    (state),
        .pre_en     (pre_en),
        .fast_en    (fast_en),
        .stat_chg_n (stat_chg_n),
        .stat_done_n(stat_done_n),
        .supply_ok  (supply_ok),
        .fault      (fault)
    );
endmodule

// File: rtl/chg_seq_checker.sv
module chg_seq_checker (
    input logic clk,
    input logic rst_n,
    input logic chg_en_n,
    input logic uvlo,
    input logic otemp,
    input logic adp_above_bat,
    input logic pre_en,
    input logic fast_en,
    input logic stat_chg_n,
    input logic stat_done_n,
    input logic supply_ok,
    input logic fault
);
    p_paths_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(pre_en && fast_en));

    p_uvlo_paths_off_r13: assert property (@(posedge clk) disable iff (!rst_n)
        uvlo |-> (!pre_en && !fast_en));

    p_otemp_paths_off_r13: assert property (@(posedge clk) disable iff (!rst_n)
        otemp |-> (!pre_en && !fast_en));

    p_uvlo_to_sleep_r13: assert property (@(posedge clk) disable iff (!rst_n)
        uvlo |=> (!supply_ok && !fault));

    p_disable_standby_r10: assert property (@(posedge clk) disable iff (!rst_n)
        chg_en_n |=> (!pre_en && !fast_en && !fault));

    p_fault_status_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (!stat_chg_n && !stat_done_n && !pre_en && !fast_en));

    p_fault_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fault && !chg_en_n && !uvlo && adp_above_bat) |=> fault);
endmodule

bind chg_seq_top chg_seq_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .chg_en_n     (chg_en_n),
    .uvlo         (uvlo),
    .otemp        (otemp),
    .adp_above_bat(adp_above_bat),
    .pre_en       (pre_en),
    .fast_en      (fast_en),
    .stat_chg_n   (stat_chg_n),
    .stat_done_n  (stat_done_n),
    .supply_ok    (supply_ok),
    .fault        (fault)
);

// File: tb/chg_seq_top_tb.sv
module chg_seq_top_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic chg_en_n = 1'b0, tmr_en_n = 1'b0, bat_above_pre = 1'b0, bat_below_rch = 1'b0;
    logic cur_below_term = 1'b0, adp_above_bat = 1'b0, uvlo = 1'b0, otemp = 1'b0, ts_out_win = 1'b0;
    logic pre_en, fast_en, stat_chg_n, stat_done_n, supply_ok, fault;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    chg_seq_top #(.DEGLITCH_TICKS(3), .PRECOND_TICKS(8), .FAST_TICKS(20)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .chg_en_n(chg_en_n), .tmr_en_n(tmr_en_n),
        .bat_above_pre(bat_above_pre), .bat_below_rch(bat_below_rch),
        .cur_below_term(cur_below_term), .adp_above_bat(adp_above_bat), .uvlo(uvlo),
        .otemp(otemp), .ts_out_win(ts_out_win), .pre_en(pre_en), .fast_en(fast_en),
        .stat_chg_n(stat_chg_n), .stat_done_n(stat_done_n), .supply_ok(supply_ok), .fault(fault)
    );

    // row: inputs {en_n,tmr_n,above_pre,below_rch,below_term,adp,uvlo,otemp,ts}
    //      ticks[7:0], expected {pre,fast,stat_chg_n,stat_done_n,supply_ok,fault}, req
    localparam int NROWS = 30;
    localparam logic [26:0] ROWS [NROWS] = '{
        {9'b000101000, 8'd0,  6'b100110, 4'd2},   // R2 start in conditioning
        {9'b001101000, 8'd0,  6'b010110, 4'd3},   // R3 rise to fast
        {9'b000101000, 8'd2,  6'b010110, 4'd4},   // R4 low, one tick short
        {9'b001101000, 8'd1,  6'b010110, 4'd4},   // R4 flag back up clears count
        {9'b000101000, 8'd2,  6'b010110, 4'd4},   // R4 count restarted
        {9'b000101000, 8'd1,  6'b100110, 4'd4},   // R4 falls back
        {9'b001011000, 8'd2,  6'b010110, 4'd5},   // R5 termination pending
        {9'b001011000, 8'd1,  6'b001010, 4'd5},   // R5 done
        {9'b001101000, 8'd2,  6'b001010, 4'd6},   // R6 recharge pending
        {9'b001101000, 8'd1,  6'b010110, 4'd6},   // R6 restart
        {9'b001101000, 8'd19, 6'b010110, 4'd8},   // R8 timer one short
        {9'b001101000, 8'd1,  6'b000011, 4'd8},   // R8 fast timer fault
        {9'b001101000, 8'd5,  6'b000011, 4'd8},   // R8 fault holds
        {9'b101101000, 8'd0,  6'b001110, 4'd10},  // R10 standby clears fault
        {9'b000101000, 8'd0,  6'b100110, 4'd2},   // R2 fresh start
        {9'b010101000, 8'd12, 6'b100110, 4'd9},   // R9 timers stopped
        {9'b000101000, 8'd4,  6'b100110, 4'd9},   // R9 timers running (4)
        {9'b000101001, 8'd3,  6'b001110, 4'd12},  // R12 suspend (timer 7)
        {9'b000101001, 8'd5,  6'b001110, 4'd12},  // R12 timer held
        {9'b000101000, 8'd0,  6'b100110, 4'd12},  // R12 resume conditioning
        {9'b000101000, 8'd1,  6'b000011, 4'd7},   // R7 conditioning timer fault
        {9'b100101000, 8'd0,  6'b001110, 4'd10},  // R10 standby
        {9'b000101000, 8'd0,  6'b100110, 4'd10},  // R10 restart
        {9'b000100000, 8'd2,  6'b100110, 4'd11},  // R11 adapter loss pending
        {9'b000100000, 8'd1,  6'b001100, 4'd11},  // R11 sleep
        {9'b001101000, 8'd0,  6'b010110, 4'd11},  // R11 adapter back, restart
        {9'b001101010, 8'd0,  6'b000110, 4'd13},  // R13 overtemp paths off
        {9'b001101000, 8'd0,  6'b010110, 4'd13},  // R13 overtemp gone
        {9'b001101100, 8'd0,  6'b001100, 4'd13},  // R13 undervoltage sleep
        {9'b001101000, 8'd0,  6'b010110, 4'd13}   // R13 recovery
    };

    task automatic check(input int req, input logic [5:0] got, input logic [5:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL R%0d: outputs got %b expected %b", req, got, exp);
        end
    endtask

    function automatic logic [5:0] outs();
        return {pre_en, fast_en, stat_chg_n, stat_done_n, supply_ok, fault};
    endfunction

    task automatic run_row(input logic [26:0] r);
        @(negedge clk);
        {chg_en_n, tmr_en_n, bat_above_pre, bat_below_rch, cur_below_term,
         adp_above_bat, uvlo, otemp, ts_out_win} = r[26:18];
        tick = 1'b0;
        @(negedge clk);
        for (int k = 0; k < int'(r[17:10]); k++) begin
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
        end
        @(negedge clk);
        check(int'(r[3:0]), outs(), r[9:4]);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(1, outs(), 6'b001100);  // R1 reset state
        @(negedge clk);
        check(1, outs(), 6'b001100);  // R1 stays asleep without adapter

        for (int i = 0; i < NROWS; i++) run_row(ROWS[i]);

        // R13: undervoltage turns the fast path off before the next edge
        @(negedge clk);
        uvlo = 1'b1;
        #1;
        check(13, {pre_en, fast_en}, 2'b00);
        @(negedge clk);
        check(13, outs(), 6'b001100);  // R13 asleep one clock later
        uvlo = 1'b0;
        @(negedge clk);
        check(11, outs(), 6'b010110);  // R11 restart into fast phase

        // R10: disable lands in standby exactly one clock later
        chg_en_n = 1'b1;
        @(negedge clk);
        check(10, outs(), 6'b001110);

        finished = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog (all requirements): got timeout expected completion");
            summary();
            $finish;
        end
    end
endmodule